// File: doc/BRIEF.md
# Decoder Host Register Bridge

This block sits between a Wishbone host and an iterative error-correction decoder core. The host uses it to load channel log-likelihood ratios into the core, to launch a decode, and to read the outcome once the core finishes. The outcome covers the convergence flag, the number of iterations used, the residual syndrome weight and the decoded information word. The bridge sends one start pulse to the core and forwards each LLR word as a one-cycle write strobe. It samples the core's results on the cycle the core reports completion.

The captured results stay readable after the core goes idle. They are cleared only at the moment the next decode is launched. The host can therefore read them at any time between two decodes. A fixed identification constant lets software confirm that the block is present. The decoding algorithm itself lives in the core and is not part of this block.

Top module: `dec_host_bridge`

## Requirements
- R1: A request (CYC and STB high, ACK low) sampled on a rising edge raises `wb_ack_o` for exactly one cycle after that edge, with the read data valid in that cycle. ACK is low in the cycle that follows.
- R2: Word address 0 reads the constant 0x00001D01. Writes to it have no effect.
- R3: Addresses with no readable register read as zero. This covers word address 1 (control), addresses 5 to 7, 9 to 63, the LLR window and everything from 116 to 255.
- R4: Writing a word with bit 0 set to address 1 raises `core_start_o` for exactly one cycle, in the cycle after the accepting edge. The write has no effect if `core_busy_i` is high at that edge.
- R5: Address 2 reads a status word: bit 0 is the live `core_busy_i`, bit 1 is done and bit 2 is converged, with all other bits zero. Done and converged are captured when `core_done_i` is high. Both are cleared by a launch.
- R6: Address 3 reads the captured iteration count and address 4 the captured syndrome weight, each zero-extended. Both are taken when `core_done_i` is high, hold while the core inputs change, and reset to zero at a launch.
- R7: Address 8 reads the captured decoded word. Its least-significant 32 bits come first, at consecutive addresses. The word is captured and cleared together with R6.
- R8: A write to address 64+j, for j from 0 to 51, pulses `llr_we_o` for one cycle after the accepting edge. The pulse carries `llr_idx_o` = j and `llr_word_o` = the written word. LLR number 5j+i sits in bits [6i+5:6i]. The write is dropped while `core_busy_i` is high and when j is 52 or more.
- R9: Writes to the status, iteration, syndrome and decoded-word addresses leave their contents unchanged.
- R10: After reset, status, iteration, syndrome and decoded word all read zero, and neither `core_start_o` nor `llr_we_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 8 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| core_start_o | output | 1 | One-cycle launch pulse to the core |
| core_busy_i | input | 1 | Core is decoding |
| core_done_i | input | 1 | Core result valid this cycle |
| core_conv_i | input | 1 | Core converged flag |
| core_iter_i | input | 8 | Core iteration count |
| core_synd_i | input | 8 | Core syndrome weight |
| core_word_i | input | 32 | Core decoded word |
| llr_we_o | output | 1 | LLR word write strobe |
| llr_idx_o | output | 6 | LLR word index |
| llr_word_o | output | 32 | LLR word, five 6-bit values packed |

## Verification
The bench builds the block with its default parameters: 256 LLRs of 6 bits, a 32-bit decoded word, and 8-bit iteration and syndrome fields. With these values the LLR window spans 52 words and ends at address 115, so the first index past its end and the unmapped gap above it are both reachable. A single decoded-word register also leaves addresses 9 to 63 open for the zero-read checks. The bench plays the core itself, so it controls whether the core is busy at each launch or LLR write. It also alters the core outputs after completion, which shows that the results are held.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  // Word addresses whose placement software relies on
  localparam int ADR_ID       = 0;
  localparam int ADR_CTRL     = 1;
  localparam int ADR_STAT     = 2;
  localparam int ADR_ITER     = 3;
  localparam int ADR_SYND     = 4;
  localparam int ADR_WORD     = 8;
  localparam int ADR_LLR      = 64;
  localparam logic [31:0] ID_VALUE = 32'h0000_1D01;

  // Status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_CONV = 2;
endpackage

// File: rtl/dbr_bus_port.sv
module dbr_bus_port (
  input  logic clk,
  input  logic rst_s,
  input  logic cyc_i,
  input  logic stb_i,
  output logic ack_o,
  output logic fire_o
);
  logic ack_q, ack_d;

  assign fire_o = cyc_i & stb_i & ~ack_q;
  assign ack_d  = fire_o;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_s)
    ack_q |=> !ack_q);
  assert_ack_req_R1: assert property (@(posedge clk) disable iff (!rst_s)
    ack_q |-> $past(cyc_i && stb_i));
endmodule

// File: rtl/dbr_launch.sv
module dbr_launch (
  input  logic clk,
  input  logic rst_s,
  input  logic req_i,
  input  logic busy_i,
  output logic launch_o,
  output logic start_o
);
  logic start_q, start_d;

  assign launch_o = req_i & ~busy_i & ~start_q;
  assign start_d  = launch_o;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign start_o = start_q;

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_s)
    start_q |=> !start_q);
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_s)
    start_q |-> !$past(busy_i));
endmodule

// File: rtl/dbr_results.sv
module dbr_results #(
  parameter int K      = 32,
  parameter int ITER_W = 8,
  parameter int SYND_W = 8
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              launch_i,
  input  logic              done_i,
  input  logic              conv_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic [SYND_W-1:0] synd_i,
  input  logic [K-1:0]      word_i,
  output logic              done_o,
  output logic              conv_o,
  output logic [ITER_W-1:0] iter_o,
  output logic [SYND_W-1:0] synd_o,
  output logic [K-1:0]      word_o
);
  logic              done_q, done_d;
  logic              conv_q, conv_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [SYND_W-1:0] synd_q, synd_d;
  logic [K-1:0]      word_q, word_d;
  logic              cap_en;

  assign cap_en = launch_i | done_i;

  // A launch clears; otherwise a completion captures
  always_comb begin
    if (launch_i) begin
      done_d = 1'b0;
      conv_d = 1'b0;
      iter_d = '0;
      synd_d = '0;
      word_d = '0;
    end else begin
      done_d = 1'b1;
      conv_d = conv_i;
      iter_d = iter_i;
      synd_d = synd_i;
      word_d = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      done_q <= 1'b0;
      conv_q <= 1'b0;
      iter_q <= '0;
      synd_q <= '0;
      word_q <= '0;
    end else if (cap_en) begin
      done_q <= done_d;
      conv_q <= conv_d;
      iter_q <= iter_d;
      synd_q <= synd_d;
      word_q <= word_d;
    end
  end

  assign done_o = done_q;
  assign conv_o = conv_q;
  assign iter_o = iter_q;
  assign synd_o = synd_q;
  assign word_o = word_q;

  assert_clear_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_s)
    launch_i |=> (!done_q && !conv_q && iter_q == '0 && synd_q == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!launch_i && !done_i) |=> ($stable(iter_q) && $stable(synd_q) && $stable(word_q) && $stable(conv_q)));
endmodule

// File: rtl/dec_host_bridge.sv
module dec_host_bridge #(
  parameter int ADDR_W = 8,
  parameter int N      = 256,
  parameter int LLR_W  = 6,
  parameter int K      = 32,
  parameter int ITER_W = 8,
  parameter int SYND_W = 8,
  localparam int LLR_PER_WORD = 32 / LLR_W,
  localparam int LLR_WORDS    = (N + LLR_PER_WORD - 1) / LLR_PER_WORD,
  localparam int LLR_IDX_W    = $clog2(LLR_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [ADDR_W-1:0]    wb_adr_i,
  input  logic [31:0]          wb_dat_i,
  output logic [31:0]          wb_dat_o,
  output logic                 wb_ack_o,
  output logic                 core_start_o,
  input  logic                 core_busy_i,
  input  logic                 core_done_i,
  input  logic                 core_conv_i,
  input  logic [ITER_W-1:0]    core_iter_i,
  input  logic [SYND_W-1:0]    core_synd_i,
  input  logic [K-1:0]         core_word_i,
  output logic                 llr_we_o,
  output logic [LLR_IDX_W-1:0] llr_idx_o,
  output logic [31:0]          llr_word_o
);
  import dbr_pkg::*;

  localparam int WORD_REGS = (K + 31) / 32;
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(ADR_ID);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_ITER = ADDR_W'(ADR_ITER);
  localparam logic [ADDR_W-1:0] A_SYND = ADDR_W'(ADR_SYND);
  localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(ADR_WORD);
  localparam logic [ADDR_W-1:0] A_LLR  = ADDR_W'(ADR_LLR);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // Bus handshake
  logic fire;
  dbr_bus_port u_port (
    .clk    (clk),
    .rst_s  (rst_s),
    .cyc_i  (wb_cyc_i),
    .stb_i  (wb_stb_i),
    .ack_o  (wb_ack_o),
    .fire_o (fire)
  );

  logic wr_fire, rd_fire;
  assign wr_fire = fire & wb_we_i;
  assign rd_fire = fire & ~wb_we_i;

  // Launch
  logic launch, start_req;
  assign start_req = wr_fire & (wb_adr_i == A_CTRL) & wb_dat_i[0];

  dbr_launch u_launch (
    .clk      (clk),
    .rst_s    (rst_s),
    .req_i    (start_req),
    .busy_i   (core_busy_i),
    .launch_o (launch),
    .start_o  (core_start_o)
  );

  // Results
  logic              res_done, res_conv;
  logic [ITER_W-1:0] res_iter;
  logic [SYND_W-1:0] res_synd;
  logic [K-1:0]      res_word;

  dbr_results #(.K(K), .ITER_W(ITER_W), .SYND_W(SYND_W)) u_res (
    .clk      (clk),
    .rst_s    (rst_s),
    .launch_i (launch),
    .done_i   (core_done_i),
    .conv_i   (core_conv_i),
    .iter_i   (core_iter_i),
    .synd_i   (core_synd_i),
    .word_i   (core_word_i),
    .done_o   (res_done),
    .conv_o   (res_conv),
    .iter_o   (res_iter),
    .synd_o   (res_synd),
    .word_o   (res_word)
  );

  // Read mux
  logic [WORD_REGS*32-1:0] word_pad;
  logic [31:0]             rd_d, rd_q;

  always_comb begin
    word_pad = '0;
    word_pad[K-1:0] = res_word;
  end

  always_comb begin
    rd_d = '0;
    if (wb_adr_i == A_ID) begin
      rd_d = ID_VALUE;
    end else if (wb_adr_i == A_STAT) begin
      rd_d[ST_BUSY] = core_busy_i;
      rd_d[ST_DONE] = res_done;
      rd_d[ST_CONV] = res_conv;
    end else if (wb_adr_i == A_ITER) begin
      rd_d[ITER_W-1:0] = res_iter;
    end else if (wb_adr_i == A_SYND) begin
      rd_d[SYND_W-1:0] = res_synd;
    end else begin
      for (int i = 0; i < WORD_REGS; i++) begin
        if (wb_adr_i == A_WORD + ADDR_W'(i)) rd_d = word_pad[i*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       rd_q <= '0;
    else if (rd_fire) rd_q <= rd_d;
  end
  assign wb_dat_o = rd_q;

  // LLR forwarding
  logic                 llr_hit;
  logic [LLR_IDX_W-1:0] llr_idx_d;
  logic                 llr_we_d, llr_we_q;
  logic [LLR_IDX_W-1:0] llr_idx_q;
  logic [31:0]          llr_word_q;

  always_comb begin
    llr_hit   = 1'b0;
    llr_idx_d = '0;
    for (int j = 0; j < LLR_WORDS; j++) begin
      if (wb_adr_i == A_LLR + ADDR_W'(j)) begin
        llr_hit   = 1'b1;
        llr_idx_d = LLR_IDX_W'(j);
      end
    end
  end

  assign llr_we_d = wr_fire & llr_hit & ~core_busy_i;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) llr_we_q <= 1'b0;
    else        llr_we_q <= llr_we_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      llr_idx_q  <= '0;
      llr_word_q <= '0;
    end else if (llr_we_d) begin
      llr_idx_q  <= llr_idx_d;
      llr_word_q <= wb_dat_i;
    end
  end

  assign llr_we_o   = llr_we_q;
  assign llr_idx_o  = llr_idx_q;
  assign llr_word_o = llr_word_q;

  assert_llr_idle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    llr_we_q |-> !$past(core_busy_i));
  assert_llr_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_s)
    llr_we_q |-> wb_ack_o);
  assert_start_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_s)
    core_start_o |-> wb_ack_o);
endmodule

// File: tb/sim_dec_host_bridge.sv
module sim_dec_host_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wb_cyc_i, wb_stb_i, wb_we_i;
  logic [7:0]  wb_adr_i;
  logic [31:0] wb_dat_i, wb_dat_o;
  logic        wb_ack_o;
  logic        core_start_o, core_busy_i, core_done_i, core_conv_i;
  logic [7:0]  core_iter_i, core_synd_i;
  logic [31:0] core_word_i;
  logic        llr_we_o;
  logic [5:0]  llr_idx_o;
  logic [31:0] llr_word_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_host_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .core_start_o(core_start_o), .core_busy_i(core_busy_i), .core_done_i(core_done_i),
    .core_conv_i(core_conv_i), .core_iter_i(core_iter_i), .core_synd_i(core_synd_i),
    .core_word_i(core_word_i),
    .llr_we_o(llr_we_o), .llr_idx_o(llr_idx_o), .llr_word_o(llr_word_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Observations captured by the bus tasks
  logic        s_start, s_start_after, s_we, s_we_after;
  logic [5:0]  s_idx;
  logic [31:0] s_word;

  // Bench model of the captured results
  logic        m_done, m_conv;
  logic [7:0]  m_iter, m_synd;
  logic [31:0] m_word;

  function automatic logic [31:0] exp_stat(logic b, logic d, logic c);
    return {29'd0, c, d, b};
  endfunction

  function automatic logic [7:0] pick_unmapped(int sel);
    case (sel % 3)
      0:       return 8'(5 + $urandom % 3);
      1:       return 8'(9 + $urandom % 55);
      default: return 8'(116 + $urandom % 140);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = a; wb_dat_i = d;
    @(negedge clk);
    chk("R1 ack on write", 32'(wb_ack_o), 32'd1);
    s_start = core_start_o; s_we = llr_we_o; s_idx = llr_idx_o; s_word = llr_word_o;
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    @(negedge clk);
    s_start_after = core_start_o; s_we_after = llr_we_o;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = a;
    @(negedge clk);
    chk("R1 ack on read", 32'(wb_ack_o), 32'd1);
    d = wb_dat_o;
    wb_cyc_i = 0; wb_stb_i = 0;
    @(negedge clk);
    chk("R1 ack drops", 32'(wb_ack_o), 32'd0);
  endtask

  task automatic check_results(input string tag);
    logic [31:0] v;
    bus_rd(8'd2, v); chk({"R5 status ", tag}, v, exp_stat(core_busy_i, m_done, m_conv));
    bus_rd(8'd3, v); chk({"R6 iter ", tag}, v, {24'd0, m_iter});
    bus_rd(8'd4, v); chk({"R6 synd ", tag}, v, {24'd0, m_synd});
    bus_rd(8'd8, v); chk({"R7 word ", tag}, v, m_word);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0; wb_adr_i = 0; wb_dat_i = 0;
    core_busy_i = 0; core_done_i = 0; core_conv_i = 0;
    core_iter_i = 8'hA5; core_synd_i = 8'h5A; core_word_i = 32'hDEAD_BEEF;
    m_done = 0; m_conv = 0; m_iter = 0; m_synd = 0; m_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 start idle", 32'(core_start_o), 32'd0);
    chk("R10 llr idle", 32'(llr_we_o), 32'd0);
    check_results("R10 after reset");

    // R2 identification and write protection
    bus_rd(8'd0, v); chk("R2 id", v, 32'h0000_1D01);
    bus_wr(8'd0, 32'hFFFF_FFFF);
    bus_rd(8'd0, v); chk("R2 id after write", v, 32'h0000_1D01);

    // R3 control reads zero
    bus_rd(8'd1, v); chk("R3 ctrl reads zero", v, 32'd0);

    // R4 start with bit 0 clear does nothing
    bus_wr(8'd1, 32'hFFFF_FFFE);
    chk("R4 no start with bit0 clear", 32'(s_start), 32'd0);

    // R8 last valid and first invalid LLR index
    bus_wr(8'd115, 32'h3FFF_FFC1);
    chk("R8 last index we", 32'(s_we), 32'd1);
    chk("R8 last index idx", 32'(s_idx), 32'd51);
    chk("R8 last index data", s_word, 32'h3FFF_FFC1);
    chk("R8 strobe one cycle", 32'(s_we_after), 32'd0);
    bus_wr(8'd116, 32'h1234_5678);
    chk("R8 past end dropped", 32'(s_we), 32'd0);
    bus_rd(8'd116, v); chk("R3 past end reads zero", v, 32'd0);
    bus_rd(8'd64, v); chk("R3 llr window reads zero", v, 32'd0);

    for (int it = 0; it < 30; it++) begin
      logic [31:0] d;
      logic [7:0]  a;
      int          j;

      // R4 launch while idle; R5/R6/R7 cleared
      bus_wr(8'd1, 32'h1 | ($urandom & 32'hFFFF_FFFE));
      chk("R4 start pulse", 32'(s_start), 32'd1);
      chk("R4 start one cycle", 32'(s_start_after), 32'd0);
      m_done = 0; m_conv = 0; m_iter = 0; m_synd = 0; m_word = 0;
      check_results("cleared at launch");

      // R8 LLR writes while idle
      j = $urandom % 52;
      d = $urandom;
      bus_wr(8'(64 + j), d);
      chk("R8 we", 32'(s_we), 32'd1);
      chk("R8 idx", 32'(s_idx), 32'(j));
      chk("R8 data", s_word, d);

      // Core busy: launch and LLR writes dropped
      @(negedge clk); core_busy_i = 1;
      bus_wr(8'd1, 32'h1);
      chk("R4 start ignored busy", 32'(s_start), 32'd0);
      bus_wr(8'(64 + $urandom % 52), $urandom);
      chk("R8 dropped while busy", 32'(s_we), 32'd0);
      bus_rd(8'd2, v); chk("R5 busy bit", v, exp_stat(1'b1, 1'b0, 1'b0));

      // Core completes
      @(negedge clk);
      core_busy_i = 0; core_done_i = 1;
      core_conv_i = 1'($urandom); core_iter_i = 8'($urandom); core_synd_i = 8'($urandom);
      core_word_i = $urandom;
      if (it == 0) begin core_iter_i = 8'hFF; core_synd_i = 8'hFF; core_word_i = 32'hFFFF_FFFF; end
      m_done = 1; m_conv = core_conv_i; m_iter = core_iter_i; m_synd = core_synd_i; m_word = core_word_i;
      @(negedge clk);
      core_done_i = 0;
      core_conv_i = ~core_conv_i; core_iter_i = 8'($urandom); core_synd_i = 8'($urandom);
      core_word_i = ~core_word_i;
      check_results("captured and held");

      // R9 writes to read-only result addresses
      a = (it % 4 == 0) ? 8'd2 : (it % 4 == 1) ? 8'd3 : (it % 4 == 2) ? 8'd4 : 8'd8;
      bus_wr(a, $urandom);
      check_results("R9 after read-only write");

      // R3 unmapped
      a = pick_unmapped(it);
      bus_wr(a, $urandom);
      bus_rd(a, v); chk("R3 unmapped zero", v, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule